// File: doc/BRIEF.md
# Stall-Cycle Accumulator with Snapshot Readout

This block is a diagnostic performance counter. It counts the clock cycles in which the processor is held up by a cache miss. Software uses the total when it tunes code for speed. The count sits in a 12-bit wrapping accumulator, and a sticky flag records whether the accumulator has wrapped.

Software reaches the block through a byte-wide register bus. The bus has an address, one-cycle read and write strobes, write data and read data.

- The high register returns the flag and the top seven accumulator bits.
- A read of the high register also copies the next four accumulator bits into a separate low holding field. Software reads that field afterwards, so the two reads give one coherent count.
- Accumulator bit 0 is never visible. The total penalty is twice the 11-bit value formed by joining the high field and the low field.
- A write to the high register reloads the upper bits from the write data. The same write clears the lower bits and the flag.

Top module: `stall_acc_regs`

## Requirements
- R1: The accumulator adds one in every clock cycle where `stall_i` is 1 and no write to the high register occurs. It holds its value when `stall_i` is 0.
- R2: The high register is at address 0x9A. With that address on `addr_i`, `rdata_o` shows the overflow flag in bit 7 and accumulator bits 11..5 in bits 6..0. The value comes combinationally from the current count.
- R3: On an increment from 0xFFF the count wraps to 0x000 and the overflow flag is set. The flag stays set until the next write to the high register.
- R4: A write to the high register does three things: it loads `wdata_i[6:0]` into accumulator bits 11..5, clears bits 4..0 and clears the overflow flag. When a stall falls in the same cycle, the write takes priority and no increment happens.
- R5: A read of the high register copies accumulator bits 4..1 into the low holding field. The copy uses the value the accumulator had before any increment in that same cycle. The field is read at address 0x9B in bits 3..0, and bits 7..4 read as zero.
- R6: The low holding field is read-only. A write to 0x9B has no effect, and the field changes only on a read of the high register.
- R7: After reset, the count, the overflow flag and the low holding field are all zero.
- R8: A read at any other address returns zero. A write to any other address has no effect on the block's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Processor stalled by a cache miss this cycle |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | One-cycle read strobe |
| wr_i | input | 1 | One-cycle write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address and state |

## Verification
The bench builds the block with its default parameters: a 12-bit accumulator, an 8-bit bus, and the high and low registers at 0x9A and 0x9B. With these widths, a write of 0x7F puts the count at 0xFE0, so the 0xFFF to 0x000 wrap and the flag it sets take only 32 stall cycles to reach. The bench also covers three same-cycle cases: a stall during a high write, a stall during a high read (the snapshot takes the pre-increment value), and writes to the read-only field and to unmapped addresses.

// File: rtl/stall_acc_pkg.sv
package stall_acc_pkg;

    // Accumulator bit where the high register field starts.
    localparam int HI_LSB = 5;
    // Accumulator bit range copied into the low holding field.
    localparam int SNAP_LSB = 1;
    localparam int SNAP_W   = HI_LSB - SNAP_LSB;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HIGH = 2'd1,
        SEL_LOW  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/stall_acc_decode.sv
module stall_acc_decode
    import stall_acc_pkg::*;
#(
    parameter int                 ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]  HI_ADDR = 8'h9A,
    parameter logic [ADDR_W-1:0]  LO_ADDR = 8'h9B
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output reg_sel_e          sel_o,
    output logic              rd_hi_o,
    output logic              wr_hi_o
);

    reg_sel_e sel_d;

    always_comb begin
        if (addr_i == HI_ADDR) begin
            sel_d = SEL_HIGH;
        end else if (addr_i == LO_ADDR) begin
            sel_d = SEL_LOW;
        end else begin
            sel_d = SEL_NONE;
        end
    end

    assign sel_o   = sel_d;
    assign rd_hi_o = rd_i && (sel_d == SEL_HIGH);
    assign wr_hi_o = wr_i && (sel_d == SEL_HIGH);

endmodule

// File: rtl/stall_acc_counter.sv
module stall_acc_counter
    import stall_acc_pkg::*;
#(
    parameter int ACC_W = 12,
    localparam int HI_W = ACC_W - HI_LSB
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stall_i,
    input  logic             load_i,
    input  logic [HI_W-1:0]  load_val_i,
    output logic [ACC_W-1:0] cnt_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [ACC_W-1:0] cnt;
        logic             ovf;
    } acc_state_t;

    acc_state_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (load_i) begin
            acc_d.cnt = {load_val_i, {HI_LSB{1'b0}}};
            acc_d.ovf = 1'b0;
        end else if (stall_i) begin
            acc_d.cnt = acc_q.cnt + ACC_W'(1);
            if (&acc_q.cnt) begin
                acc_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign cnt_o = acc_q.cnt;
    assign ovf_o = acc_q.ovf;

endmodule

// File: rtl/stall_acc_snapshot.sv
module stall_acc_snapshot
    import stall_acc_pkg::*;
#(
    parameter int ACC_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              capture_i,
    input  logic [ACC_W-1:0]  cnt_i,
    output logic [SNAP_W-1:0] snap_o
);

    typedef struct packed {
        logic [SNAP_W-1:0] bits;
    } snap_state_t;

    snap_state_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (capture_i) begin
            snap_d.bits = cnt_i[HI_LSB-1:SNAP_LSB];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    assign snap_o = snap_q.bits;

endmodule

// File: rtl/stall_acc_regs.sv
module stall_acc_regs
    import stall_acc_pkg::*;
#(
    parameter int                ACC_W   = 12,
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h9A,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h9B
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stall_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int HI_W = ACC_W - HI_LSB;

    reg_sel_e          sel;
    logic              rd_hi;
    logic              wr_hi;
    logic [ACC_W-1:0]  acc_cnt;
    logic              acc_ovf;
    logic [SNAP_W-1:0] snap_val;
    logic [DATA_W-1:0] rdata_d;
    logic              unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:HI_W];

    stall_acc_decode #(
        .ADDR_W  (ADDR_W),
        .HI_ADDR (HI_ADDR),
        .LO_ADDR (LO_ADDR)
    ) u_decode (
        .addr_i  (addr_i),
        .rd_i    (rd_i),
        .wr_i    (wr_i),
        .sel_o   (sel),
        .rd_hi_o (rd_hi),
        .wr_hi_o (wr_hi)
    );

    stall_acc_counter #(
        .ACC_W (ACC_W)
    ) u_counter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stall_i    (stall_i),
        .load_i     (wr_hi),
        .load_val_i (wdata_i[HI_W-1:0]),
        .cnt_o      (acc_cnt),
        .ovf_o      (acc_ovf)
    );

    stall_acc_snapshot #(
        .ACC_W (ACC_W)
    ) u_snapshot (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (rd_hi),
        .cnt_i     (acc_cnt),
        .snap_o    (snap_val)
    );

    always_comb begin
        unique case (sel)
            SEL_HIGH: rdata_d = DATA_W'({acc_ovf, acc_cnt[ACC_W-1:HI_LSB]});
            SEL_LOW:  rdata_d = DATA_W'(snap_val);
            default:  rdata_d = '0;
        endcase
    end

    assign rdata_o = rdata_d;

endmodule

// File: rtl/stall_acc_chk.sv
module stall_acc_chk
    import stall_acc_pkg::*;
#(
    parameter int                ACC_W   = 12,
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h9A,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h9B
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              stall_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [ACC_W-1:0]  cnt,
    input logic              ovf,
    input logic [SNAP_W-1:0] snap
);

    localparam int HI_W = ACC_W - HI_LSB;

    logic wr_hi_c;
    logic rd_hi_c;
    assign wr_hi_c = wr_i && (addr_i == HI_ADDR);
    assign rd_hi_c = rd_i && (addr_i == HI_ADDR);

    // R1
    a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_i && !wr_hi_c) |=> (cnt == ACC_W'($past(cnt) + ACC_W'(1))));

    // R1
    a_r1_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stall_i && !wr_hi_c) |=> $stable(cnt));

    // R3
    a_r3_wrap_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_i && !wr_hi_c && (&cnt)) |=> (ovf && (cnt == '0)));

    // R3
    a_r3_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf && !wr_hi_c) |=> ovf);

    // R4
    a_r4_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_hi_c |=> (!ovf && (cnt[HI_LSB-1:0] == '0)
                     && (cnt[ACC_W-1:HI_LSB] == $past(wdata_i[HI_W-1:0]))));

    // R5
    a_r5_snapshot_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_hi_c |=> (snap == $past(cnt[HI_LSB-1:SNAP_LSB])));

    // R6
    a_r6_snapshot_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_hi_c |=> $stable(snap));

    // R2
    a_r2_high_readout: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == HI_ADDR) |-> (rdata_o == DATA_W'({ovf, cnt[ACC_W-1:HI_LSB]})));

    // R8
    a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((addr_i != HI_ADDR) && (addr_i != LO_ADDR)) |-> (rdata_o == '0));

endmodule

bind stall_acc_regs stall_acc_chk #(
    .ACC_W   (ACC_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .HI_ADDR (HI_ADDR),
    .LO_ADDR (LO_ADDR)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stall_i (stall_i),
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .cnt     (acc_cnt),
    .ovf     (acc_ovf),
    .snap    (snap_val)
);

// File: tb/test_stall_acc_regs.sv
`timescale 1ns/1ps
module test_stall_acc_regs;

    localparam logic [7:0] HI = 8'h9A;
    localparam logic [7:0] LO = 8'h9B;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] exp;
        string      req;
    } item_t;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       stall_i = 1'b0;
    logic [7:0] addr_i = '0;
    logic       rd_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    item_t sb[$];

    // bench reference state
    logic [11:0] m_cnt = '0;
    logic        m_ovf = 1'b0;
    logic [3:0]  m_low = '0;

    always #10 clk_i = ~clk_i;

    stall_acc_regs i_stall_acc_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .stall_i (stall_i),
        .addr_i  (addr_i),
        .rd_i    (rd_i),
        .wr_i    (wr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o)
    );

    function automatic void model_step(bit st);
        if (st) begin
            if (m_cnt == 12'hFFF) m_ovf = 1'b1;
            m_cnt = m_cnt + 12'd1;
        end
    endfunction

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk_i);
            #1;
        end
    endtask

    task automatic stalls(int n);
        for (int i = 0; i < n; i++) begin
            stall_i = 1'b1;
            @(posedge clk_i);
            model_step(1'b1);
            #1;
            stall_i = 1'b0;
        end
    endtask

    task automatic wr_reg(logic [7:0] a, logic [7:0] d, bit st);
        addr_i  = a;
        wdata_i = d;
        wr_i    = 1'b1;
        stall_i = st;
        @(posedge clk_i);
        if (a == HI) begin
            m_cnt = {d[6:0], 5'b0};
            m_ovf = 1'b0;
        end else begin
            model_step(st);
        end
        #1;
        wr_i    = 1'b0;
        stall_i = 1'b0;
        addr_i  = '0;
    endtask

    task automatic rd_reg(logic [7:0] a, string req, bit st);
        item_t it;
        it.addr = a;
        it.req  = req;
        if (a == HI)      it.exp = {m_ovf, m_cnt[11:5]};
        else if (a == LO) it.exp = {4'b0, m_low};
        else              it.exp = 8'h00;
        sb.push_back(it);
        addr_i  = a;
        rd_i    = 1'b1;
        stall_i = st;
        @(posedge clk_i);
        if (a == HI) m_low = m_cnt[4:1];
        model_step(st);
        #1;
        rd_i    = 1'b0;
        stall_i = 1'b0;
        addr_i  = '0;
    endtask

    // monitor: compare read data against the scoreboard away from the edge
    always @(negedge clk_i) begin
        if (rst_ni && rd_i) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL %s: read with no expected item, got %02h", "R2", rdata_o);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (rdata_o !== it.exp) begin
                    fails++;
                    $display("FAIL %s: addr %02h actual %02h expected %02h",
                             it.req, it.addr, rdata_o, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #1;
        rst_ni = 1'b1;

        // R7: reset state
        rd_reg(HI, "R7", 1'b0);
        rd_reg(LO, "R7", 1'b0);

        // R1: count stall cycles, idle gaps do not count
        stalls(37);
        idle(5);
        rd_reg(HI, "R1", 1'b0);
        rd_reg(LO, "R5", 1'b0);
        stalls(3);
        idle(2);
        stalls(60);
        rd_reg(HI, "R2", 1'b0);
        rd_reg(LO, "R5", 1'b0);

        // R6: low field keeps old snapshot while counting continues
        stalls(10);
        rd_reg(LO, "R6", 1'b0);
        wr_reg(LO, 8'hFF, 1'b0);
        rd_reg(LO, "R6", 1'b0);
        rd_reg(HI, "R6", 1'b0);

        // R4: write loads upper bits, clears lower bits
        stalls(7);
        wr_reg(HI, 8'h05, 1'b0);
        rd_reg(HI, "R4", 1'b0);
        rd_reg(LO, "R4", 1'b0);

        // R3: preload near the top, wrap, sticky flag
        wr_reg(HI, 8'h7F, 1'b0);
        stalls(31);
        rd_reg(HI, "R3", 1'b0);
        rd_reg(LO, "R3", 1'b0);
        stalls(1);
        rd_reg(HI, "R3", 1'b0);
        stalls(40);
        rd_reg(HI, "R3", 1'b0);
        rd_reg(LO, "R3", 1'b0);

        // R4: write clears flag; write beats a same-cycle stall
        stalls(9);
        wr_reg(HI, 8'h12, 1'b1);
        rd_reg(HI, "R4", 1'b0);
        rd_reg(LO, "R4", 1'b0);
        wr_reg(HI, 8'h80, 1'b0);
        rd_reg(HI, "R4", 1'b0);

        // R5: read with stall in same cycle captures pre-increment value
        stalls(13);
        rd_reg(HI, "R5", 1'b1);
        rd_reg(LO, "R5", 1'b0);
        rd_reg(HI, "R5", 1'b0);
        rd_reg(LO, "R5", 1'b0);

        // R8: unmapped address reads zero, write has no effect
        rd_reg(8'h10, "R8", 1'b0);
        wr_reg(8'h10, 8'h55, 1'b0);
        rd_reg(8'h99, "R8", 1'b0);
        rd_reg(HI, "R8", 1'b0);
        rd_reg(LO, "R8", 1'b0);

        idle(2);
        if (sb.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R2: %0d reads never observed, expected 0", sb.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule